// File: doc/BRIEF.md
# Lane-Striped ECC Link with Hot-Spare Remapping

This block moves a parallel data word across many slow serial lanes, one bit per lane per clock. The transmit half places the data bits and Hamming check bits on logical lanes, adds one lane of overall even parity, and steers every logical lane onto a physical lane through a remap table. The receive half reads the physical lanes back through its own copy of the table, forms the syndrome, repairs any single wrong lane and flags words that it cannot repair. All lanes share one forwarded clock, and a forwarded valid lane travels beside them. Lanes are assumed to arrive in the same cycle, with no skew.

A monitor watches which physical lane the corrections land on. When the same physical lane draws a programmable number of corrections in a row, its logical lane is moved onto the lowest unused spare physical lane. The transmit table switches first and the receive table switches one edge later, so both switch on the same word and no word is lost. Once the spares are used up, the block reports exhaustion and carries on in correction-only mode. Per-lane correction counters and the threshold are reached through a small register port.

Top module: `lane_stripe_link`

## Requirements
- R1: Logical lane order: lane 0 holds even parity over lanes 1..10. Lanes 1, 2, 4 and 8 hold Hamming check bits. Data bits 0..5 sit on lanes 3, 5, 6, 7, 9 and 10. After reset, logical lane k drives physical lane k, and spare physical lanes 11 and 12 are driven 0. A word presented before edge n is on `tx_lanes` after edge n. With a zero-delay channel it is on `rx_data` after edge n+1, and `rx_valid` follows `tx_valid` along the same path.
- R2: A word with exactly one wrong active lane (parity, check or data) comes out with its sent data, `rx_corrected`=1 and `rx_bad`=0.
- R3: A word with two wrong lanes gives `rx_bad`=1 and `rx_corrected`=0. Its data bits are passed on as received, with no repair.
- R4: Odd overall parity together with a syndrome above 10 gives `rx_bad`=1. The data is passed on unchanged.
- R5: A move is made when corrections fall on the same physical lane threshold-many times in a row. Clean words do not break the run, and a correction on another lane restarts the count at 1. The logical lane is then moved to the lowest unused spare. The word that is in flight at the switch is still decoded with the old table. No word is corrupted, and once the move is done the failed physical lane is no longer read.
- R6: With spares available, two lane failures in sequence leave the output error-free, provided the first move completes before the second failure.
- R7: `spare_left` starts at 2 and drops by one per move. At 0, `spare_none`=1, no further moves happen, and single errors are still corrected.
- R8: Each physical lane has a 4-bit count of the corrections attributed to it, which saturates at 15. A read of register address i (i < 13) returns the count for lane i. A write to address i clears that count.
- R9: Register address 31 holds the failure threshold, which is 8 after reset. A write to address 31 sets it, and a read returns it.
- R10: After reset: `rx_valid`=0, `spare_left`=2, `spare_none`=0, all counters 0 and the threshold 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded clock shared by all lanes |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | 6 | Word to send |
| tx_valid | input | 1 | Word on tx_data is valid |
| tx_lanes | output | 13 | Physical lanes toward the channel |
| tx_lane_vld | output | 1 | Forwarded valid lane |
| rx_lanes | input | 13 | Physical lanes from the channel |
| rx_lane_vld | input | 1 | Received forwarded valid lane |
| rx_data | output | 6 | Decoded word |
| rx_valid | output | 1 | rx_data holds a word |
| rx_corrected | output | 1 | One lane was repaired in this word |
| rx_bad | output | 1 | Word could not be repaired and is invalid |
| spare_left | output | 2 | Unused spare lanes |
| spare_none | output | 1 | All spares are in use |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |

## Verification
If a remap table is wrong or the tables fall out of step, the first word after the bad switch carries one misplaced lane. That shows up at once as an unexpected `rx_corrected`. When a stuck lane is also present, it shows as `rx_bad` or wrong data one edge after the word leaves the transmit lanes. A run counter or spare pointer with a bad value shows as a move that comes too early or too late. The bench sees that in the exact count of 9 read back for the failed lane, and in `spare_left` within a few cycles of the last correction. Counter faults show on the first read after the affected correction.

// File: rtl/lane_ecc_pkg.sv
package lane_ecc_pkg;

    typedef enum logic [1:0] {
        DEC_CLEAN = 2'd0,
        DEC_FIX   = 2'd1,
        DEC_BAD   = 2'd2
    } dec_kind_t;

    typedef struct packed {
        logic valid;
        logic corrected;
        logic bad;
    } rx_flags_t;

    // smallest count of Hamming check lanes covering dw data lanes
    function automatic int par_lanes(input int dw);
        for (int p = 1; p < 31; p++) begin
            if ((1 << p) >= dw + p + 1) return p;
        end
        return 31;
    endfunction

    function automatic logic is_pow2(input int v);
        return (v & (v - 1)) == 0;
    endfunction

endpackage

// File: rtl/lane_tx_enc.sv
module lane_tx_enc
    import lane_ecc_pkg::*;
#(
    parameter int DATA_W = 6,
    parameter int CODE_W = 11,
    parameter int PHYS   = 13,
    parameter int PIDX_W = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [DATA_W-1:0]              data,
    input  logic                           valid,
    input  logic [CODE_W-1:0][PIDX_W-1:0]  tbl,
    output logic [PHYS-1:0]                lanes,
    output logic                           lane_vld
);
    localparam int HP = CODE_W - DATA_W - 1;

    logic [PHYS-1:0] phys_c;

    always_comb begin
        logic [CODE_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                c[p] = data[k];
                k++;
            end
        end
        for (int j = 0; j < HP; j++) begin
            logic acc;
            acc = 1'b0;
            for (int p = 3; p < CODE_W; p++) begin
                if (!is_pow2(p) && ((p >> j) & 1) == 1) acc ^= c[p];
            end
            c[1 << j] = acc;
        end
        c[0] = ^c[CODE_W-1:1];
        phys_c = '0;
        for (int l = 0; l < CODE_W; l++) phys_c[tbl[l]] = c[l];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes    <= '0;
            lane_vld <= 1'b0;
        end else begin
            lanes    <= phys_c;
            lane_vld <= valid;
        end
    end

endmodule

// File: rtl/lane_rx_dec.sv
module lane_rx_dec
    import lane_ecc_pkg::*;
#(
    parameter int DATA_W = 6,
    parameter int CODE_W = 11,
    parameter int PHYS   = 13,
    parameter int PIDX_W = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [PHYS-1:0]                lanes,
    input  logic                           lane_vld,
    input  logic [CODE_W-1:0][PIDX_W-1:0]  tbl,
    output logic [DATA_W-1:0]              data_q,
    output rx_flags_t                      flags_q,
    output logic                           ev_corr,
    output logic [CODE_W-DATA_W-2:0]       ev_lane
);
    localparam int HP = CODE_W - DATA_W - 1;

    dec_kind_t         kind;
    logic [DATA_W-1:0] dout;
    logic [HP-1:0]     syn;

    always_comb begin
        logic [CODE_W-1:0] c;
        logic [HP-1:0]     s;
        logic              odd;
        int                k;
        for (int l = 0; l < CODE_W; l++) c[l] = lanes[tbl[l]];
        s = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (c[p]) s ^= HP'(p);
        end
        odd = ^c;
        if (!odd && s == '0)                 kind = DEC_CLEAN;
        else if (odd && int'(s) < CODE_W)    kind = DEC_FIX;
        else                                 kind = DEC_BAD;
        if (kind == DEC_FIX) c[s] = ~c[s];
        dout = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                dout[k] = c[p];
                k++;
            end
        end
        syn = s;
    end

    assign ev_corr = lane_vld && (kind == DEC_FIX);
    assign ev_lane = syn;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            flags_q <= '0;
        end else begin
            data_q            <= dout;
            flags_q.valid     <= lane_vld;
            flags_q.corrected <= lane_vld && (kind == DEC_FIX);
            flags_q.bad       <= lane_vld && (kind == DEC_BAD);
        end
    end

    // R3: a word is never both repaired and rejected
    assert_flag_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(flags_q.corrected && flags_q.bad));

    // R1: forwarded valid reaches the output one edge later
    assert_vld_pipe_R1: assert property (@(posedge clk) disable iff (rst)
        lane_vld |=> flags_q.valid);

endmodule

// File: rtl/lane_fail_mon.sv
module lane_fail_mon
    import lane_ecc_pkg::*;
#(
    parameter int CODE_W  = 11,
    parameter int PHYS    = 13,
    parameter int PIDX_W  = 4,
    parameter int HP      = 4,
    parameter int NSPARE  = 2,
    parameter int SP_W    = 2,
    parameter int CNT_W   = 4,
    parameter int THR_W   = 5,
    parameter int THR_RST = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ev_corr,
    input  logic [HP-1:0]                  ev_lane,
    input  logic                           thr_wr,
    input  logic [THR_W-1:0]               thr_wdata,
    input  logic [PHYS-1:0]                cnt_clr,
    output logic [CODE_W-1:0][PIDX_W-1:0]  tx_tbl,
    output logic [CODE_W-1:0][PIDX_W-1:0]  rx_tbl,
    output logic [THR_W-1:0]               thresh,
    output logic [PHYS-1:0][CNT_W-1:0]     cnt,
    output logic [SP_W-1:0]                spare_left,
    output logic                           spare_none
);
    logic [SP_W-1:0]   spare_used;
    logic              pend;
    logic [HP-1:0]     pend_lane;
    logic [PIDX_W-1:0] pend_phys;
    logic [PIDX_W-1:0] run_lane;
    logic [THR_W-1:0]  run_cnt;
    logic [THR_W-1:0]  run_nx;
    logic [PIDX_W-1:0] hit;
    logic [PIDX_W-1:0] new_phys;
    logic              fire;

    assign hit        = rx_tbl[ev_lane];
    assign spare_none = (spare_used == SP_W'(NSPARE));
    assign spare_left = SP_W'(NSPARE) - spare_used;
    assign new_phys   = PIDX_W'(CODE_W) + PIDX_W'(spare_used);

    always_comb begin
        if (run_cnt != '0 && run_lane == hit)
            run_nx = (run_cnt == '1) ? run_cnt : run_cnt + 1'b1;
        else
            run_nx = THR_W'(1);
    end

    assign fire = ev_corr && !pend && !spare_none && (run_nx >= thresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < CODE_W; l++) begin
                tx_tbl[l] <= PIDX_W'(l);
                rx_tbl[l] <= PIDX_W'(l);
            end
            spare_used <= '0;
            pend       <= 1'b0;
            pend_lane  <= '0;
            pend_phys  <= '0;
            run_lane   <= '0;
            run_cnt    <= '0;
            thresh     <= THR_W'(THR_RST);
        end else begin
            if (thr_wr) thresh <= thr_wdata;
            if (pend) begin
                rx_tbl[pend_lane] <= pend_phys;
                pend              <= 1'b0;
            end
            if (ev_corr) begin
                run_lane <= hit;
                run_cnt  <= run_nx;
            end
            if (fire) begin
                tx_tbl[ev_lane] <= new_phys;
                pend            <= 1'b1;
                pend_lane       <= ev_lane;
                pend_phys       <= new_phys;
                spare_used      <= spare_used + 1'b1;
                run_cnt         <= '0;
            end
        end
    end

    for (genvar i = 0; i < PHYS; i++) begin : g_cnt
        logic [CNT_W-1:0] c_q;
        always_ff @(posedge clk) begin
            if (rst)
                c_q <= '0;
            else if (cnt_clr[i])
                c_q <= '0;
            else if (ev_corr && hit == PIDX_W'(i) && c_q != '1)
                c_q <= c_q + 1'b1;
        end
        assign cnt[i] = c_q;

        // R8: a full counter stays full until cleared
        assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (c_q == '1 && !cnt_clr[i]) |=> c_q == '1);
    end

    // R5: both tables agree except in the single hand-off cycle
    assert_tbl_agree_R5: assert property (@(posedge clk) disable iff (rst)
        !pend |-> (tx_tbl == rx_tbl));

    // R7: exhaustion is permanent until reset
    assert_exhaust_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        spare_none |=> spare_none);

    // R7: no transmit move once spares are gone
    assert_no_move_exhausted_R7: assert property (@(posedge clk) disable iff (rst)
        spare_none |=> $stable(tx_tbl));

endmodule

// File: rtl/lane_stripe_link.sv
module lane_stripe_link
    import lane_ecc_pkg::*;
#(
    parameter int DATA_W  = 6,
    parameter int NSPARE  = 2,
    parameter int CNT_W   = 4,
    parameter int THR_W   = 5,
    parameter int THR_RST = 8,
    parameter int ADDR_W  = 5,
    parameter int REG_W   = 8,
    localparam int HP     = par_lanes(DATA_W),
    localparam int CODE_W = DATA_W + HP + 1,
    localparam int PHYS   = CODE_W + NSPARE,
    localparam int SP_W   = $clog2(NSPARE + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DATA_W-1:0]  tx_data,
    input  logic               tx_valid,
    output logic [PHYS-1:0]    tx_lanes,
    output logic               tx_lane_vld,
    input  logic [PHYS-1:0]    rx_lanes,
    input  logic               rx_lane_vld,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_valid,
    output logic               rx_corrected,
    output logic               rx_bad,
    output logic [SP_W-1:0]    spare_left,
    output logic               spare_none,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata
);
    localparam int PIDX_W   = $clog2(PHYS);
    localparam int THR_ADDR = (1 << ADDR_W) - 1;

    logic [CODE_W-1:0][PIDX_W-1:0] tx_tbl;
    logic [CODE_W-1:0][PIDX_W-1:0] rx_tbl;
    logic [PHYS-1:0][CNT_W-1:0]    cnt;
    logic [PHYS-1:0]               cnt_clr;
    logic [THR_W-1:0]              thresh;
    logic                          ev_corr;
    logic [HP-1:0]                 ev_lane;
    logic                          thr_wr;
    rx_flags_t                     flags;

    lane_tx_enc #(.DATA_W(DATA_W), .CODE_W(CODE_W), .PHYS(PHYS), .PIDX_W(PIDX_W)) u_tx (
        .clk(clk), .rst(rst), .data(tx_data), .valid(tx_valid), .tbl(tx_tbl),
        .lanes(tx_lanes), .lane_vld(tx_lane_vld)
    );

    lane_rx_dec #(.DATA_W(DATA_W), .CODE_W(CODE_W), .PHYS(PHYS), .PIDX_W(PIDX_W)) u_rx (
        .clk(clk), .rst(rst), .lanes(rx_lanes), .lane_vld(rx_lane_vld), .tbl(rx_tbl),
        .data_q(rx_data), .flags_q(flags), .ev_corr(ev_corr), .ev_lane(ev_lane)
    );

    lane_fail_mon #(
        .CODE_W(CODE_W), .PHYS(PHYS), .PIDX_W(PIDX_W), .HP(HP), .NSPARE(NSPARE),
        .SP_W(SP_W), .CNT_W(CNT_W), .THR_W(THR_W), .THR_RST(THR_RST)
    ) u_mon (
        .clk(clk), .rst(rst), .ev_corr(ev_corr), .ev_lane(ev_lane),
        .thr_wr(thr_wr), .thr_wdata(reg_wdata[THR_W-1:0]), .cnt_clr(cnt_clr),
        .tx_tbl(tx_tbl), .rx_tbl(rx_tbl), .thresh(thresh), .cnt(cnt),
        .spare_left(spare_left), .spare_none(spare_none)
    );

    assign rx_valid     = flags.valid;
    assign rx_corrected = flags.corrected;
    assign rx_bad       = flags.bad;

    assign thr_wr = reg_wr && (reg_addr == ADDR_W'(THR_ADDR));
    for (genvar i = 0; i < PHYS; i++) begin : g_clr
        assign cnt_clr[i] = reg_wr && (reg_addr == ADDR_W'(i));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(THR_ADDR))
            reg_rdata = REG_W'(thresh);
        else if (int'(reg_addr) < PHYS)
            reg_rdata = REG_W'(cnt[reg_addr]);
    end

    // R2: a repaired word is never also flagged bad at the ports
    assert_fix_not_bad_R2: assert property (@(posedge clk) disable iff (rst)
        rx_corrected |-> (!rx_bad && rx_valid));

endmodule

// File: tb/sim_lane_stripe_link.sv
module sim_lane_stripe_link;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic [12:0] tx_lanes;
    logic        tx_lane_vld;
    logic [12:0] rx_lanes;
    logic [5:0]  rx_data;
    logic        rx_valid, rx_corrected, rx_bad;
    logic [1:0]  spare_left;
    logic        spare_none;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;

    logic [12:0] flip = '0;
    logic [12:0] stk0 = '0;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] d;
        logic       c;
        logic       b;
        logic       chkc;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    // channel: stuck-at-0 lanes and one-word flips
    assign rx_lanes = (tx_lanes & ~stk0) ^ flip;

    lane_stripe_link u0 (
        .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_lanes(tx_lanes), .tx_lane_vld(tx_lane_vld),
        .rx_lanes(rx_lanes), .rx_lane_vld(tx_lane_vld),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_corrected(rx_corrected), .rx_bad(rx_bad),
        .spare_left(spare_left), .spare_none(spare_none),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [5:0] d, input logic [12:0] fl, input logic ec,
                        input logic eb, input logic chkc, input logic [5:0] dx, input string tag);
        exp_t e;
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        e.d = dx; e.c = ec; e.b = eb; e.chkc = chkc; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        #1 flip = fl;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tx_valid = 1'b0;
            @(posedge clk);
            #1 flip = '0;
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && rx_valid) begin
            if (q.size() == 0) begin
                nchk++; nfail++;
                $display("FAIL R1 word with no expectation actual=%0h expected=none", rx_data);
            end else begin
                exp_t e;
                e = q.pop_front();
                nchk++;
                if (rx_data !== e.d || rx_bad !== e.b || (e.chkc && rx_corrected !== e.c)) begin
                    nfail++;
                    $display("FAIL %s actual=d%0h c%0b b%0b expected=d%0h c%0b b%0b",
                             e.tag, rx_data, rx_corrected, rx_bad, e.d, e.c, e.b);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk("R10 rx_valid", rx_valid, 0);
        chk("R10 spare_left", spare_left, 2);
        chk("R10 spare_none", spare_none, 0);
        rd(5'd3, v);  chk("R10 counter", v, 0);
        rd(5'd31, v); chk("R10 threshold", v, 8);

        // R1 lane placement for hand-computed words
        send(6'h01, '0, 0, 0, 1, 6'h01, "R1 clean");
        chk("R1 lanes data bit0", tx_lanes, 13'h00F);
        send(6'h20, '0, 0, 0, 1, 6'h20, "R1 clean");
        chk("R1 lanes data bit5", tx_lanes, 13'h505);
        send(6'h3F, '0, 0, 0, 1, 6'h3F, "R1 clean");
        send(6'h00, '0, 0, 0, 1, 6'h00, "R1 clean");
        send(6'h2D, '0, 0, 0, 1, 6'h2D, "R1 clean");

        // R2 single-lane repairs on parity, data and check lanes
        send(6'h2A, 13'h001, 1, 0, 1, 6'h2A, "R2 overall lane");
        send(6'h2A, 13'h008, 1, 0, 1, 6'h2A, "R2 data lane 3");
        send(6'h15, 13'h400, 1, 0, 1, 6'h15, "R2 data lane 10");
        send(6'h15, 13'h010, 1, 0, 1, 6'h15, "R2 check lane 4");

        // R3 two lanes wrong: data bits 0 and 1 pass through flipped
        send(6'h15, 13'h028, 0, 1, 1, 6'h16, "R3 double");
        // R4 lanes 1,2,8 wrong: syndrome 11, odd parity
        send(6'h33, 13'h106, 0, 1, 1, 6'h33, "R4 invalid syndrome");
        idle(2);
        rd(5'd3, v);  chk("R8 count lane 3", v, 1);
        rd(5'd10, v); chk("R8 count lane 10", v, 1);
        rd(5'd5, v);  chk("R8 lane 5 uncounted", v, 0);

        // R5 lane 6 (data bit 2) stuck at 0
        stk0 = 13'h040;
        for (int i = 0; i < 20; i++)
            send(6'(i * 9) | 6'h04, '0, 0, 0, 0, 6'(i * 9) | 6'h04, "R5 during move");
        idle(2);
        chk("R5 spare_left", spare_left, 1);
        chk("R5 spare_none", spare_none, 0);
        rd(5'd6, v);  chk("R5 moved after 8 plus in-flight word", v, 9);
        rd(5'd11, v); chk("R5 spare clean", v, 0);
        for (int i = 0; i < 4; i++)
            send(6'(i * 16) | 6'h04, '0, 0, 0, 1, 6'(i * 16) | 6'h04, "R5 failed lane unused");

        // R6 second failure: lane 7 (data bit 3) stuck at 0
        stk0 = 13'h0C0;
        for (int i = 0; i < 20; i++)
            send(6'(i * 5) | 6'h0C, '0, 0, 0, 0, 6'(i * 5) | 6'h0C, "R6 second failure");
        idle(2);
        chk("R7 spare_left", spare_left, 0);
        chk("R7 spare_none", spare_none, 1);
        rd(5'd7, v); chk("R6 lane 7 count", v, 9);
        for (int i = 0; i < 4; i++)
            send(6'(i * 32) | 6'h0C, '0, 0, 0, 1, 6'(i * 32) | 6'h0C, "R6 two failed lanes clean");

        // R7 third failure, no spares: correction only
        stk0 = 13'h2C0;
        for (int i = 0; i < 24; i++)
            send(6'(i & 3) | 6'h1C, '0, 1, 0, 1, 6'(i & 3) | 6'h1C, "R7 correction-only");
        idle(2);
        chk("R7 still no spare", spare_left, 0);
        rd(5'd9, v); chk("R8 saturated", v, 15);

        // R3 a further lane error on top of the stuck lane corrupts
        send(6'h1C, 13'h400, 0, 1, 1, 6'h2C, "R3 second error uncorrectable");
        idle(2);

        wr(5'd9, 8'd0);
        rd(5'd9, v); chk("R8 clear", v, 0);
        rd(5'd6, v); chk("R8 clear touches one lane", v, 9);
        wr(5'd31, 8'd5);
        rd(5'd31, v); chk("R9 threshold write", v, 5);

        idle(3);
        chk("R1 all words delivered", q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule